// File: doc/BRIEF.md
# Transceiver Reconfiguration Handshake Sequencer

This block is the user-side partner of a link-layer core that needs its serial transmitter retuned while running. The core asks for work on two independent request lines. The first changes the link bit rate. The reference clock stays fixed at 135 MHz, so a new rate is reached only by picking a different transmit PLL divide ratio. The second updates the analog drive settings, which are the output voltage swing and the pre-emphasis level. Each request is answered with an acknowledge pulse and a busy flag. The new settings are latched and presented on a shared management port with a one-cycle write strobe. Busy is held until the modelled transceiver returns a done strobe.

Both channels drive the same management port, so at most one operation is in flight. When both requests are pending, the rate request goes first. After reset the sequencer writes a default configuration to every target and waits for that write to complete. No request is acknowledged before then.

Top module: `xrs_reconf_seq`

## Requirements
- R1: A request sampled high while the sequencer is idle produces an acknowledge that is high for exactly one cycle, in the cycle after the sampling edge. No acknowledge appears without a request in the previous cycle.
- R2: Busy of the serviced channel rises in the same cycle as its acknowledge. It stays high until `mgmt_done` is sampled high, and it is low in the cycle after that edge.
- R3: A rate request with code 0 (low rate), 1 (high rate) or 2 (highest rate) drives `mgmt_div` equal to the code and `mgmt_sel` to 1. It raises `mgmt_wr` for one cycle, in the acknowledge cycle.
- R4: Rate code 3 is ignored. There is no `mgmt_wr`, and `mgmt_div` keeps its prior value. The handshake still runs: acknowledge, then busy high for exactly that one cycle, with no `mgmt_done` needed.
- R5: An analog request latches `ana_swing` and `ana_emph` onto `mgmt_swing` and `mgmt_emph`, sets `mgmt_sel` to 2, and follows the same acknowledge, busy and write timing as R1 to R3.
- R6: After reset, while held: no acknowledge, no busy, no write. In the first cycle after release, `mgmt_wr` pulses with `mgmt_sel` = 3 and the default divide, swing and emphasis values. No request is acknowledged until the done strobe for that write has been seen.
- R7: If both requests are pending while the sequencer is idle, the rate request is acknowledged first. The analog request waits and is acknowledged one cycle after rate busy falls.
- R8: Rate busy and analog busy are never high together.
- R9: While busy is high, `mgmt_div`, `mgmt_swing` and `mgmt_emph` hold their values even if the request inputs change.
- R10: A request still high after busy falls counts as a new request. It is acknowledged one cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_req | input | 1 | Rate change request from the core |
| rate_code | input | 2 | Requested rate code (0..2 legal, 3 ignored) |
| rate_ack | output | 1 | One-cycle acknowledge for the rate channel |
| rate_busy | output | 1 | Rate reconfiguration in progress |
| ana_req | input | 1 | Analog settings request from the core |
| ana_swing | input | SWING_W | Requested voltage-swing code |
| ana_emph | input | EMPH_W | Requested pre-emphasis code |
| ana_ack | output | 1 | One-cycle acknowledge for the analog channel |
| ana_busy | output | 1 | Analog reconfiguration in progress |
| mgmt_wr | output | 1 | One-cycle write strobe to the transceiver |
| mgmt_sel | output | 2 | Write target: 1 rate, 2 analog, 3 all |
| mgmt_div | output | 2 | Transmit PLL divide ratio selector |
| mgmt_swing | output | SWING_W | Voltage-swing setting |
| mgmt_emph | output | EMPH_W | Pre-emphasis setting |
| mgmt_done | input | 1 | Completion strobe from the transceiver |

## Verification
A request driven in one cycle yields acknowledge, busy, the write strobe and the new settings exactly one cycle later. Busy falls one cycle after `mgmt_done` is driven, or one cycle after the acknowledge when the rate code is 3. A waiting or repeated request is acknowledged one cycle after busy falls. The bench drives on the falling edge and checks on the next falling edge that matches this count. A bench-side responder varies the done latency from zero to several cycles, and at each intermediate cycle the bench checks that busy is still high and the settings are unchanged. Random transactions use a fixed seed and are mixed with directed cases for reset-time requests, simultaneous requests, code 3 and held requests.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  localparam int RATE_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_INIT_WAIT,
    ST_IDLE,
    ST_RATE,
    ST_ANA,
    ST_SKIP
  } seq_state_e;

  localparam logic [SEL_W-1:0] TGT_RATE   = 2'd1;
  localparam logic [SEL_W-1:0] TGT_ANALOG = 2'd2;
  localparam logic [SEL_W-1:0] TGT_ALL    = 2'd3;

  // Only codes below three name a real rate.
  function automatic logic rate_is_legal(input logic [RATE_W-1:0] code);
    return code < RATE_W'(3);
  endfunction

  // Divide selector equals the rate code for the legal range.
  function automatic logic [RATE_W-1:0] rate_to_div(input logic [RATE_W-1:0] code);
    return code;
  endfunction

endpackage

// File: rtl/xrs_arb.sv
module xrs_arb (
  input  logic idle,
  input  logic rate_req,
  input  logic ana_req,
  output logic grant_rate,
  output logic grant_ana
);
  // Fixed priority: rate wins, analog waits.
  always_comb begin
    grant_rate = idle & rate_req;
    grant_ana  = idle & ana_req & ~rate_req;
  end
endmodule

// File: rtl/xrs_chan.sv
module xrs_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic finish,
  output logic ack,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      busy <= 1'b0;
    end else begin
      ack <= grant;
      if (grant)
        busy <= 1'b1;
      else if (finish)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/xrs_mgmt.sv
module xrs_mgmt
  import xrs_pkg::*;
#(
  parameter int SWING_W = 2,
  parameter int EMPH_W  = 2,
  parameter logic [RATE_W-1:0]  DEF_DIV   = '0,
  parameter logic [SWING_W-1:0] DEF_SWING = '0,
  parameter logic [EMPH_W-1:0]  DEF_EMPH  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_init,
  input  logic               ld_rate,
  input  logic               ld_ana,
  input  logic [RATE_W-1:0]  rate_code,
  input  logic [SWING_W-1:0] swing_in,
  input  logic [EMPH_W-1:0]  emph_in,
  output logic               wr,
  output logic [SEL_W-1:0]   sel,
  output logic [RATE_W-1:0]  div,
  output logic [SWING_W-1:0] swing,
  output logic [EMPH_W-1:0]  emph
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr    <= 1'b0;
      sel   <= '0;
      div   <= DEF_DIV;
      swing <= DEF_SWING;
      emph  <= DEF_EMPH;
    end else begin
      wr <= ld_init | ld_rate | ld_ana;
      if (ld_init) begin
        sel   <= TGT_ALL;
        div   <= DEF_DIV;
        swing <= DEF_SWING;
        emph  <= DEF_EMPH;
      end else if (ld_rate) begin
        sel <= TGT_RATE;
        div <= rate_to_div(rate_code);
      end else if (ld_ana) begin
        sel   <= TGT_ANALOG;
        swing <= swing_in;
        emph  <= emph_in;
      end
    end
  end
endmodule

// File: rtl/xrs_reconf_seq.sv
module xrs_reconf_seq
  import xrs_pkg::*;
#(
  parameter int SWING_W = 2,
  parameter int EMPH_W  = 2,
  parameter logic [RATE_W-1:0]  DEF_DIV   = 2'd0,
  parameter logic [SWING_W-1:0] DEF_SWING = 2'd1,
  parameter logic [EMPH_W-1:0]  DEF_EMPH  = 2'd0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rate_req,
  input  logic [1:0]         rate_code,
  output logic               rate_ack,
  output logic               rate_busy,
  input  logic               ana_req,
  input  logic [SWING_W-1:0] ana_swing,
  input  logic [EMPH_W-1:0]  ana_emph,
  output logic               ana_ack,
  output logic               ana_busy,
  output logic               mgmt_wr,
  output logic [1:0]         mgmt_sel,
  output logic [1:0]         mgmt_div,
  output logic [SWING_W-1:0] mgmt_swing,
  output logic [EMPH_W-1:0]  mgmt_emph,
  input  logic               mgmt_done
);
  localparam int NCH = 2;
  localparam int CH_RATE = 0;
  localparam int CH_ANA  = 1;

  seq_state_e state, state_nxt;

  // Named internal events, visible to the checker.
  logic seq_idle, seq_ready, init_issue, init_done_evt;
  logic grant_rate, grant_ana, rate_legal, svc_skip, svc_rate_ld;
  logic [NCH-1:0] grant_v, finish_v, ack_v, busy_v;

  always_comb begin
    seq_idle      = (state == ST_IDLE);
    seq_ready     = (state != ST_INIT) && (state != ST_INIT_WAIT);
    init_issue    = (state == ST_INIT);
    init_done_evt = (state == ST_INIT_WAIT) && mgmt_done;
    rate_legal    = rate_is_legal(rate_code);
    svc_skip      = grant_rate & ~rate_legal;
    svc_rate_ld   = grant_rate & rate_legal;
  end

  xrs_arb u_arb (
    .idle       (seq_idle),
    .rate_req   (rate_req),
    .ana_req    (ana_req),
    .grant_rate (grant_rate),
    .grant_ana  (grant_ana)
  );

  always_comb begin
    grant_v[CH_RATE]  = grant_rate;
    grant_v[CH_ANA]   = grant_ana;
    finish_v[CH_RATE] = ((state == ST_RATE) && mgmt_done) || (state == ST_SKIP);
    finish_v[CH_ANA]  = (state == ST_ANA) && mgmt_done;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    xrs_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .grant  (grant_v[g]),
      .finish (finish_v[g]),
      .ack    (ack_v[g]),
      .busy   (busy_v[g])
    );
  end

  assign rate_ack  = ack_v[CH_RATE];
  assign rate_busy = busy_v[CH_RATE];
  assign ana_ack   = ack_v[CH_ANA];
  assign ana_busy  = busy_v[CH_ANA];

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_INIT:      state_nxt = ST_INIT_WAIT;
      ST_INIT_WAIT: if (init_done_evt) state_nxt = ST_IDLE;
      ST_IDLE: begin
        if (svc_rate_ld)   state_nxt = ST_RATE;
        else if (svc_skip) state_nxt = ST_SKIP;
        else if (grant_ana) state_nxt = ST_ANA;
      end
      ST_RATE:  if (mgmt_done) state_nxt = ST_IDLE;
      ST_ANA:   if (mgmt_done) state_nxt = ST_IDLE;
      ST_SKIP:  state_nxt = ST_IDLE;
      default:  state_nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_INIT;
    else        state <= state_nxt;
  end

  xrs_mgmt #(
    .SWING_W   (SWING_W),
    .EMPH_W    (EMPH_W),
    .DEF_DIV   (DEF_DIV),
    .DEF_SWING (DEF_SWING),
    .DEF_EMPH  (DEF_EMPH)
  ) u_mgmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_init   (init_issue),
    .ld_rate   (svc_rate_ld),
    .ld_ana    (grant_ana),
    .rate_code (rate_code),
    .swing_in  (ana_swing),
    .emph_in   (ana_emph),
    .wr        (mgmt_wr),
    .sel       (mgmt_sel),
    .div       (mgmt_div),
    .swing     (mgmt_swing),
    .emph      (mgmt_emph)
  );
endmodule

// File: rtl/xrs_seq_chk.sv
module xrs_seq_chk #(
  parameter int SWING_W = 2,
  parameter int EMPH_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rate_req,
  input logic               rate_ack,
  input logic               rate_busy,
  input logic               ana_req,
  input logic               ana_ack,
  input logic               ana_busy,
  input logic               mgmt_wr,
  input logic               mgmt_done,
  input logic [1:0]         mgmt_div,
  input logic [SWING_W-1:0] mgmt_swing,
  input logic [EMPH_W-1:0]  mgmt_emph,
  input logic               seq_ready,
  input logic               svc_skip
);
  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ack |=> !rate_ack);
  p_ack_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ack |-> $past(rate_req));
  p_busy_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ack |-> rate_busy);
  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rate_busy) |-> ($past(mgmt_done) || $past(svc_skip, 2)));
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_wr |=> !mgmt_wr);
  p_skip_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_skip |=> (rate_ack && !mgmt_wr));
  p_ana_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ana_ack |-> ($past(ana_req) && ana_busy));
  p_init_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_ack || ana_ack) |-> seq_ready);
  p_rate_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_req && ana_req && seq_ready && !rate_busy && !ana_busy) |=> (rate_ack && !ana_ack));
  p_one_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rate_busy && ana_busy));
  p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate_busy || ana_busy) && $past(rate_busy || ana_busy))
      |-> ($stable(mgmt_div) && $stable(mgmt_swing) && $stable(mgmt_emph)));
endmodule

bind xrs_reconf_seq xrs_seq_chk #(
  .SWING_W (SWING_W),
  .EMPH_W  (EMPH_W)
) u_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_req   (rate_req),
  .rate_ack   (rate_ack),
  .rate_busy  (rate_busy),
  .ana_req    (ana_req),
  .ana_ack    (ana_ack),
  .ana_busy   (ana_busy),
  .mgmt_wr    (mgmt_wr),
  .mgmt_done  (mgmt_done),
  .mgmt_div   (mgmt_div),
  .mgmt_swing (mgmt_swing),
  .mgmt_emph  (mgmt_emph),
  .seq_ready  (seq_ready),
  .svc_skip   (svc_skip)
);

// File: tb/xrs_reconf_seq_bench.sv
module xrs_reconf_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 2;
  localparam int EW = 2;
  localparam logic [1:0]    D_DIV   = 2'd0;
  localparam logic [SW-1:0] D_SWING = 2'd1;
  localparam logic [EW-1:0] D_EMPH  = 2'd0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_req = 1'b0;
  logic [1:0] rate_code = '0;
  logic ana_req = 1'b0;
  logic [SW-1:0] ana_swing = '0;
  logic [EW-1:0] ana_emph = '0;
  logic mgmt_done = 1'b0;
  logic rate_ack, rate_busy, ana_ack, ana_busy, mgmt_wr;
  logic [1:0] mgmt_sel, mgmt_div;
  logic [SW-1:0] mgmt_swing;
  logic [EW-1:0] mgmt_emph;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  logic [1:0] sh_div;
  logic [SW-1:0] sh_swing;
  logic [EW-1:0] sh_emph;

  always #(CLK_PERIOD/2) clk = ~clk;

  xrs_reconf_seq u_xrs_reconf_seq (
    .clk(clk), .rst_n(rst_n),
    .rate_req(rate_req), .rate_code(rate_code), .rate_ack(rate_ack), .rate_busy(rate_busy),
    .ana_req(ana_req), .ana_swing(ana_swing), .ana_emph(ana_emph),
    .ana_ack(ana_ack), .ana_busy(ana_busy),
    .mgmt_wr(mgmt_wr), .mgmt_sel(mgmt_sel), .mgmt_div(mgmt_div),
    .mgmt_swing(mgmt_swing), .mgmt_emph(mgmt_emph), .mgmt_done(mgmt_done)
  );

  function automatic bit exp_legal(input logic [1:0] c);
    return c != 2'd3;
  endfunction

  function automatic logic [1:0] exp_div(input logic [1:0] c, input logic [1:0] prev);
    return exp_legal(c) ? c : prev;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic finish_with_done(input string req, input int lat, input bit is_rate);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk_eq(req, "busy held", is_rate ? int'(rate_busy) : int'(ana_busy), 1);
      chk_eq("R1", "ack single", is_rate ? int'(rate_ack) : int'(ana_ack), 0);
      chk_eq("R3", "wr single", int'(mgmt_wr), 0);
      chk_eq("R9", "div stable", int'(mgmt_div), int'(sh_div));
      chk_eq("R9", "swing stable", int'(mgmt_swing), int'(sh_swing));
      chk_eq("R9", "emph stable", int'(mgmt_emph), int'(sh_emph));
    end
    mgmt_done = 1'b1;
    @(negedge clk);
    mgmt_done = 1'b0;
    chk_eq("R2", "busy falls after done", is_rate ? int'(rate_busy) : int'(ana_busy), 0);
  endtask

  task automatic rate_txn(input logic [1:0] code, input int lat);
    rate_req = 1'b1;
    rate_code = code;
    @(negedge clk);
    rate_req = 1'b0;
    rate_code = 2'($urandom);
    chk_eq("R1", "rate ack", int'(rate_ack), 1);
    chk_eq("R2", "rate busy with ack", int'(rate_busy), 1);
    chk_eq("R8", "analog idle", int'(ana_busy), 0);
    sh_div = exp_div(code, sh_div);
    if (exp_legal(code)) begin
      chk_eq("R3", "rate wr", int'(mgmt_wr), 1);
      chk_eq("R3", "rate sel", int'(mgmt_sel), 1);
      chk_eq("R3", "div", int'(mgmt_div), int'(sh_div));
      finish_with_done("R2", lat, 1'b1);
    end else begin
      chk_eq("R4", "no wr code3", int'(mgmt_wr), 0);
      chk_eq("R4", "div kept", int'(mgmt_div), int'(sh_div));
      @(negedge clk);
      chk_eq("R4", "busy one cycle", int'(rate_busy), 0);
      chk_eq("R4", "div kept after", int'(mgmt_div), int'(sh_div));
    end
  endtask

  task automatic ana_txn(input logic [SW-1:0] sw, input logic [EW-1:0] em, input int lat);
    ana_req = 1'b1;
    ana_swing = sw;
    ana_emph = em;
    @(negedge clk);
    ana_req = 1'b0;
    ana_swing = SW'($urandom);
    ana_emph = EW'($urandom);
    sh_swing = sw;
    sh_emph = em;
    chk_eq("R5", "ana ack", int'(ana_ack), 1);
    chk_eq("R5", "ana busy", int'(ana_busy), 1);
    chk_eq("R8", "rate idle", int'(rate_busy), 0);
    chk_eq("R5", "ana wr", int'(mgmt_wr), 1);
    chk_eq("R5", "ana sel", int'(mgmt_sel), 2);
    chk_eq("R5", "swing", int'(mgmt_swing), int'(sw));
    chk_eq("R5", "emph", int'(mgmt_emph), int'(em));
    finish_with_done("R5", lat, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    sh_div = D_DIV;
    sh_swing = D_SWING;
    sh_emph = D_EMPH;

    // R6: reset state, with a rate request already pending
    rate_req = 1'b1;
    rate_code = 2'd1;
    repeat (3) @(negedge clk);
    chk_eq("R6", "ack in reset", int'(rate_ack), 0);
    chk_eq("R6", "busy in reset", int'(rate_busy | ana_busy), 0);
    chk_eq("R6", "wr in reset", int'(mgmt_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R6", "init wr", int'(mgmt_wr), 1);
    chk_eq("R6", "init sel", int'(mgmt_sel), 3);
    chk_eq("R6", "init div", int'(mgmt_div), int'(D_DIV));
    chk_eq("R6", "init swing", int'(mgmt_swing), int'(D_SWING));
    chk_eq("R6", "init emph", int'(mgmt_emph), int'(D_EMPH));
    chk_eq("R6", "no ack during init", int'(rate_ack), 0);
    repeat (2) begin
      @(negedge clk);
      chk_eq("R6", "still no ack", int'(rate_ack), 0);
    end
    mgmt_done = 1'b1;
    @(negedge clk);
    mgmt_done = 1'b0;
    chk_eq("R6", "no ack on done edge", int'(rate_ack), 0);
    @(negedge clk);
    rate_req = 1'b0;
    chk_eq("R6", "ack after init", int'(rate_ack), 1);
    sh_div = 2'd1;
    chk_eq("R3", "div after init req", int'(mgmt_div), 1);
    finish_with_done("R2", 1, 1'b1);

    // Directed: each rate code, including the ignored one
    rate_txn(2'd2, 0);
    rate_txn(2'd3, 0);
    rate_txn(2'd0, 3);
    ana_txn(2'd3, 2'd2, 2);

    // R7: both pending together
    rate_req = 1'b1; rate_code = 2'd2;
    ana_req = 1'b1; ana_swing = 2'd2; ana_emph = 2'd3;
    @(negedge clk);
    rate_req = 1'b0;
    sh_div = 2'd2;
    chk_eq("R7", "rate first", int'(rate_ack), 1);
    chk_eq("R7", "analog waits", int'(ana_ack), 0);
    mgmt_done = 1'b1;
    @(negedge clk);
    mgmt_done = 1'b0;
    chk_eq("R7", "rate busy falls", int'(rate_busy), 0);
    chk_eq("R7", "analog not yet", int'(ana_ack), 0);
    @(negedge clk);
    ana_req = 1'b0;
    sh_swing = 2'd2; sh_emph = 2'd3;
    chk_eq("R7", "analog served next", int'(ana_ack), 1);
    chk_eq("R7", "analog sel", int'(mgmt_sel), 2);
    finish_with_done("R5", 1, 1'b0);

    // R10: request held through completion
    rate_req = 1'b1; rate_code = 2'd0;
    @(negedge clk);
    sh_div = 2'd0;
    chk_eq("R10", "first ack", int'(rate_ack), 1);
    mgmt_done = 1'b1;
    @(negedge clk);
    mgmt_done = 1'b0;
    chk_eq("R10", "busy low", int'(rate_busy), 0);
    chk_eq("R10", "no ack yet", int'(rate_ack), 0);
    @(negedge clk);
    rate_req = 1'b0;
    chk_eq("R10", "repeat ack", int'(rate_ack), 1);
    finish_with_done("R2", 0, 1'b1);

    // Random mix
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(1, 0) == 0)
        rate_txn(2'($urandom), int'($urandom_range(4, 0)));
      else
        ana_txn(SW'($urandom), EW'($urandom), int'($urandom_range(4, 0)));
      if ($urandom_range(2, 0) == 0) begin
        @(negedge clk);
        chk_eq("R1", "idle no ack", int'(rate_ack | ana_ack), 0);
      end
    end

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule